// File: doc/BRIEF.md
# Radix-4 Recoded Sequential Signed Multiplier

This block multiplies two signed two's complement operands of `W` bits and returns a product of `2W` bits. The multiplier operand is split into overlapping three-bit windows. Each window becomes one signed digit with a value of -2, -1, 0, +1 or +2. One digit is used per clock, so a full product takes `W/2` cycles. In each cycle the datapath adds zero, the multiplicand, twice the multiplicand, or the negation of either to a running partial sum. It then shifts the sum right arithmetically by two places.

A client holds the operands on the inputs and pulses `start` while the unit is idle. The unit reports `busy` while it works and pulses `done` for one cycle when the result lands in the product register. The product register keeps that value until the next multiplication finishes. Positive and negative operands follow the same steps, and no sign fix-up is applied at the end. `W` must be even and defaults to 8.

Top module: `r4_booth_mul`

## Requirements
- R1: While reset is asserted and directly after its release, `busy` and `done` are 0 and `product` is 0.
- R2: Digit k is formed from multiplier bits (2k+1, 2k, 2k-1), with a 0 standing in for bit -1. The window values map to digits as follows: 011 gives +2, 100 gives -2, 001 and 010 give +1, 101 and 110 give -1, and 000 and 111 give 0.
- R3: On completion `product` holds the exact signed product of the two operands captured at the accepted start, for every sign combination (for example 21 × 14 = 294).
- R4: After an accepted start, `busy` is high for exactly `W/2` cycles for every multiplier value, including alternating bit patterns. `done` is then high for exactly one cycle, with `busy` low.
- R5: A `start` that arrives while `busy` is high is ignored. It does not change the result or the cycle count, and it does not begin a second run.
- R6: `product` changes only in the cycle where `done` rises. While no run completes it stays stable, whatever the operand inputs do.
- R7: Extreme operands give correct products: (-2^(W-1))×(-2^(W-1)) = 2^(2W-2), and the full-scale mixed-sign cases are also exact.
- R8: `done` and `busy` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin; only accepted while idle |
| mcand_i | input | W | Signed multiplicand, sampled when start is accepted |
| mplr_i | input | W | Signed multiplier, sampled when start is accepted |
| busy | output | 1 | High while recoding steps are in progress |
| done | output | 1 | One-cycle pulse when the product register is updated |
| product | output | 2W | Signed product, held between completions |

## Verification
The bench sweeps every 8-bit multiplier value against several multiplicands, including both full-scale extremes. This reaches each window code in every digit position. A wrong window mapping, or a missing implicit zero below the multiplier LSB, would give off-by-M or off-by-2M products. A partial sum that is too narrow, or that is shifted without sign extension, would wrap when -128 is multiplied by -128. The bench also raises `start` again in the middle of a run with different operands. A unit that restarts or resamples on that pulse would report the second pair's product or a longer busy window. Finally, the bench toggles the operands between runs. This exposes a product register that follows the live inputs instead of holding its value.

// File: rtl/r4m_pkg.sv
package r4m_pkg;

  // One recoded signed digit: magnitude one-hot over {1,2}, plus a sign.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } r4_digit_t;

endpackage

// File: rtl/r4m_recode.sv
module r4m_recode
  import r4m_pkg::*;
(
  input  logic [2:0] win,
  output r4_digit_t  dig
);

  always_comb begin
    dig = '0;
    unique case (win)
      3'b001, 3'b010: dig.one = 1'b1;
      3'b011:         dig.two = 1'b1;
      3'b100:         begin dig.two = 1'b1; dig.neg = 1'b1; end
      3'b101, 3'b110: begin dig.one = 1'b1; dig.neg = 1'b1; end
      default:        dig = '0;
    endcase
  end

endmodule

// File: rtl/r4m_step.sv
module r4m_step
  import r4m_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W+1:0] acc,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplr,
  input  r4_digit_t    dig,
  output logic [W+1:0] acc_nx,
  output logic [W-1:0] mplr_nx
);

  localparam int AW = W + 2;

  logic [AW-1:0] m_x1;
  logic [AW-1:0] m_x2;
  logic [AW-1:0] mag;
  logic [AW-1:0] addend;
  logic [AW-1:0] sum;

  always_comb begin
    m_x1   = {{2{mcand[W-1]}}, mcand};
    m_x2   = {mcand[W-1], mcand, 1'b0};
    mag    = dig.two ? m_x2 : (dig.one ? m_x1 : '0);
    addend = dig.neg ? (~mag + AW'(1)) : mag;
    sum    = acc + addend;
    // arithmetic right shift by two of {sum, mplr}
    acc_nx  = {{2{sum[AW-1]}}, sum[AW-1:2]};
    mplr_nx = {sum[1:0], mplr[W-1:2]};
  end

endmodule

// File: rtl/r4m_ctrl.sv
module r4m_ctrl #(
  parameter int STEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load_en,
  output logic step_en,
  output logic last_step
);

  localparam int CW = $clog2(STEPS) + 1;

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          busy_q, busy_nx;
  logic          done_q, done_nx;

  always_comb begin
    load_en   = start & ~busy_q;
    step_en   = busy_q;
    last_step = busy_q & (cnt_q == CW'(STEPS - 1));

    busy_nx = busy_q;
    if (load_en)        busy_nx = 1'b1;
    else if (last_step) busy_nx = 1'b0;

    done_nx = last_step;

    cnt_nx = cnt_q;
    if (load_en)      cnt_nx = '0;
    else if (step_en) cnt_nx = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      busy_q <= busy_nx;
      done_q <= done_nx;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/r4_booth_mul.sv
module r4_booth_mul
  import r4m_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplr_i,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);

  localparam int STEPS = W / 2;
  localparam int AW    = W + 2;
  localparam int PW    = 2 * W;

  logic load_en, step_en, last_step;

  logic [AW-1:0] acc_q, acc_d, acc_nx;
  logic [W-1:0]  mq_q, mq_d, mq_nx;
  logic          qm1_q, qm1_d;
  logic [W-1:0]  mcand_q, mcand_d;
  logic [PW-1:0] prod_q, prod_d;
  r4_digit_t     cur_dig;

  r4m_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .load_en   (load_en),
    .step_en   (step_en),
    .last_step (last_step)
  );

  r4m_recode u_rec (
    .win (({mq_q[1:0], qm1_q})),
    .dig (cur_dig)
  );

  r4m_step #(.W(W)) u_step (
    .acc     (acc_q),
    .mcand   (mcand_q),
    .mplr    (mq_q),
    .dig     (cur_dig),
    .acc_nx  (acc_nx),
    .mplr_nx (mq_nx)
  );

  always_comb begin
    acc_d   = acc_q;
    mq_d    = mq_q;
    qm1_d   = qm1_q;
    mcand_d = mcand_q;
    prod_d  = prod_q;
    if (load_en) begin
      acc_d   = '0;
      mq_d    = mplr_i;
      qm1_d   = 1'b0;
      mcand_d = mcand_i;
    end else if (step_en) begin
      acc_d = acc_nx;
      mq_d  = mq_nx;
      qm1_d = mq_q[1];
    end
    if (last_step) prod_d = {acc_nx[W-1:0], mq_nx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mq_q    <= '0;
      qm1_q   <= 1'b0;
      mcand_q <= '0;
      prod_q  <= '0;
    end else begin
      acc_q   <= acc_d;
      mq_q    <= mq_d;
      qm1_q   <= qm1_d;
      mcand_q <= mcand_d;
      prod_q  <= prod_d;
    end
  end

  assign product = prod_q;

endmodule

// File: rtl/r4m_chk.sv
module r4m_chk
  import r4m_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product,
  input r4_digit_t      dig
);

  localparam int STEPS = W / 2;
  localparam int CW    = $clog2(STEPS + 1) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= '0;
    else if (start && !busy) run_cnt <= '0;
    else if (busy)           run_cnt <= run_cnt + CW'(1);
  end

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == CW'(STEPS))); // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R5
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product)); // R6
  AST_DIGIT_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot0({dig.one, dig.two})); // R2
  AST_DIGIT_ZERO_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dig.one && !dig.two) |-> !dig.neg); // R2

endmodule

bind r4_booth_mul r4m_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product),
  .dig     (cur_dig)
);

// File: tb/sim_r4_booth_mul.sv
module sim_r4_booth_mul;

  localparam int W     = 8;
  localparam int STEPS = W / 2;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [W-1:0]   mcand_i;
  logic [W-1:0]   mplr_i;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int n_chk  = 0;
  int n_fail = 0;
  logic [2*W-1:0] exp_q[$];
  logic [2*W-1:0] last_exp;

  r4_booth_mul #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand_i(mcand_i),
    .mplr_i(mplr_i), .busy(busy), .done(done), .product(product)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W-1:0]   sa;
    logic signed [W-1:0]   sb;
    logic signed [2*W-1:0] p;
    sa = a;
    sb = b;
    p  = sa * sb;
    return p;
  endfunction

  // monitor: pops the scoreboard when a result is flagged (R3, R7)
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R5 unexpected result", 32'(product), 32'hDEAD);
      else                   chk("R3 product", 32'(product), 32'(exp_q.pop_front()));
    end
  end

  // driver: one multiplication, optionally with a stray start mid-run (R5)
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    int n;
    n = 0;
    @(negedge clk);
    mcand_i = a;
    mplr_i  = b;
    start   = 1'b1;
    last_exp = ref_mul(a, b);
    exp_q.push_back(last_exp);
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      n++;
      if (poke && n == 2) begin
        start   = 1'b1;
        mcand_i = ~a;
        mplr_i  = b ^ 8'h5A;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (n > 4 * STEPS) break;
    end
    start = 1'b0;
    chk("R4 busy cycles", 32'(n), 32'(STEPS));
    chk("R4 done after busy", 32'(done), 32'd1);
  endtask

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    mcand_i = '0;
    mplr_i  = '0;
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 product in reset", 32'(product), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", 32'(busy), 32'd0);
    chk("R1 product after release", 32'(product), 32'd0);

    // R3 sign combinations, 21 x 14
    run(8'd21, 8'd14, 1'b0);
    run(-8'sd21, 8'd14, 1'b0);
    run(8'd21, -8'sd14, 1'b0);
    run(-8'sd21, -8'sd14, 1'b0);

    // R2 each window code at the low digit (implicit zero below LSB) and above
    run(8'd1, 8'h01, 1'b0);
    run(8'd1, 8'h02, 1'b0);
    run(8'd1, 8'h03, 1'b0);
    run(8'd1, 8'h04, 1'b0);
    run(8'd1, 8'h06, 1'b0);
    run(8'd1, 8'hFE, 1'b0);
    run(8'd1, 8'hFF, 1'b0);

    // R4 alternating patterns still take W/2 cycles
    run(8'd37, 8'h55, 1'b0);
    run(8'd37, 8'hAA, 1'b0);

    // R7 extremes
    run(8'h80, 8'h80, 1'b0);
    run(8'h7F, 8'h80, 1'b0);
    run(8'h80, 8'h7F, 1'b0);
    run(8'h7F, 8'h7F, 1'b0);

    // R2/R3 sweep every multiplier value
    foreach (int_list[i]) begin
      for (int b = 0; b < 256; b++) run(int_list[i], 8'(b), 1'b0);
    end

    // R5 stray start during a run
    run(8'd21, 8'd14, 1'b1);
    run(-8'sd99, 8'd77, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk("R5 no second run", 32'(busy), 32'd0);
    end

    // R6 product holds while inputs move without start
    for (int k = 0; k < 5; k++) begin
      mcand_i = 8'(k * 37 + 5);
      mplr_i  = 8'(k * 91 + 3);
      @(negedge clk);
      chk("R6 product held", 32'(product), 32'(last_exp));
      chk("R8 done idle", 32'(done), 32'd0);
    end

    chk("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  logic [W-1:0] int_list [6] = '{8'd3, 8'hF9, 8'h7F, 8'h80, 8'd1, 8'd0};

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule